// File: doc/BRIEF.md
# MSI-X Vector Table and Pending-Array Responder

This block answers memory-mapped accesses to one base address region that holds a table of message-signalled interrupt vectors, followed by a pending-bit array. Software writes each vector's address, data and control words with 32-bit or 64-bit accesses and reads them back. The block rejects accesses of the wrong size or the wrong alignment, and also accesses that fall outside both regions. A read of any such location returns all ones.

The device logic raises an interrupt by presenting a vector index on the trigger port. The block looks up that entry and checks the capability enable, the function-wide mask, the plain-MSI enable and the entry's own mask bit. When all of them allow it, the block emits one message carrying an 8-bit destination and an 8-bit vector. Pending-bit bookkeeping for masked vectors is not kept, so the pending array always reads as zero. The enable and mask inputs come from capability registers that live outside this block.

Top module: `msix_bar_resp`

## Requirements
- R1: Only accesses with req_size_i equal to 4 or 8 bytes take effect. A write of any other size changes nothing. A read of any other size returns 64'hFFFF_FFFF_FFFF_FFFF.
- R2: Each vector entry occupies 16 bytes, and its index is the offset shifted right by 4. Within an entry, dword offset 0 is address low, 4 is address high, 8 is message data and 12 is vector control. A 4-byte access at a 4-aligned offset touches one dword, and its read data is zero-extended in bits 63:32.
- R3: An 8-byte access must be 8-aligned. It writes dwords (off, off+4) from wdata[31:0] and wdata[63:32], and it reads back {dword off+4, dword off}. A read that is misaligned for its size returns all ones, and a misaligned write is dropped.
- R4: A write whose index is at or beyond NUM_VEC is dropped and aliases no entry. A read there returns all ones, unless the offset lies in the pending array.
- R5: The pending array starts at NUM_VEC*16 rounded up to a 4096-byte boundary (0x1000 by default). It spans 8 bytes for each 64 vectors. Reads inside it return zero, and reads past its end return all ones.
- R6: After reset, every entry reads zero, except vector control, which reads 32'h1 (bit 0 is the per-vector mask).
- R7: A read accepted on one clock edge raises rsp_valid_o for exactly the following cycle. A write produces no response.
- R8: A trigger produces a message only when msix_en_i is 1, msix_fmask_i is 0, the index is below NUM_VEC, and the entry's mask bit is 0.
- R9: A message appears on msg_valid_o in the cycle after the trigger. msg_dest_o carries bits 19:12 of the entry's address low word, and msg_vec_o carries bits 7:0 of its data word.
- R10: While msi_en_i is 1, no message is produced, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access request strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | BAR_AW | Byte offset within the region |
| req_size_i | input | 4 | Access size in bytes |
| req_wdata_i | input | 64 | Write data |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_rdata_o | output | 64 | Read data |
| msix_en_i | input | 1 | Vector messaging enabled |
| msix_fmask_i | input | 1 | Function-wide mask |
| msi_en_i | input | 1 | Plain MSI enabled; overrides vector messaging |
| trig_valid_i | input | 1 | Interrupt request from the device |
| trig_index_i | input | TRIG_W | Vector index to signal |
| msg_valid_o | output | 1 | Message strobe |
| msg_dest_o | output | 8 | Message destination |
| msg_vec_o | output | 8 | Message vector |

## Verification
The bench writes to an index one past the last vector and then reads entry 0. A design that wraps the index would corrupt that entry instead of dropping the write. It also issues 2-byte writes and misaligned 8-byte writes, then reads the targeted words back. A design that half-honours these accesses shows the stray data there. Reads are aimed just inside and just past the pending array, and at the gap between the table and that array. A design with a wrong boundary returns zero where all ones is due, or the reverse. Triggers are sent with each gate closed in turn: entry mask, function mask, plain-MSI enable, cleared enable and an out-of-range index. A design that drops any one term emits a message where none should appear.

// File: rtl/msix_resp_pkg.sv
package msix_resp_pkg;

  // dword slots within one 16-byte entry
  localparam int unsigned DW_ADDR_LO = 0;
  localparam int unsigned DW_ADDR_HI = 1;
  localparam int unsigned DW_DATA    = 2;
  localparam int unsigned DW_VCTRL   = 3;

  typedef logic [3:0][31:0] vec_entry_t;

  function automatic int unsigned pba_offset(int unsigned n_vec);
    return ((n_vec * 16 + 4095) / 4096) * 4096;
  endfunction

  function automatic int unsigned pba_bytes(int unsigned n_vec);
    return ((n_vec - 1) / 64 + 1) * 8;
  endfunction

endpackage

// File: rtl/msix_acc_decode.sv
module msix_acc_decode
  import msix_resp_pkg::*;
#(
  parameter int unsigned NUM_VEC = 8,
  parameter int unsigned ADDR_W  = 13,
  parameter int unsigned IDX_W   = 3
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        size_i,
  output logic              size_ok_o,
  output logic              size8_o,
  output logic              aligned_o,
  output logic              in_table_o,
  output logic              in_pba_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [1:0]        dw_o
);
  localparam int unsigned PBA_LO_I = pba_offset(NUM_VEC);
  localparam int unsigned PBA_HI_I = PBA_LO_I + pba_bytes(NUM_VEC);
  localparam logic [ADDR_W:0]   PBA_LO  = (ADDR_W+1)'(PBA_LO_I);
  localparam logic [ADDR_W:0]   PBA_HI  = (ADDR_W+1)'(PBA_HI_I);
  localparam logic [ADDR_W-5:0] VEC_LIM = (ADDR_W-4)'(NUM_VEC);

  logic [ADDR_W-5:0] ent;
  logic              size4;

  assign ent        = addr_i[ADDR_W-1:4];
  assign size4      = (size_i == 4'd4);
  assign size8_o    = (size_i == 4'd8);
  assign size_ok_o  = size4 | size8_o;
  assign aligned_o  = size8_o ? (addr_i[2:0] == 3'b000) : (addr_i[1:0] == 2'b00);
  assign in_table_o = (ent < VEC_LIM);
  assign in_pba_o   = ({1'b0, addr_i} >= PBA_LO) && ({1'b0, addr_i} < PBA_HI);
  assign idx_o      = ent[IDX_W-1:0];
  assign dw_o       = addr_i[3:2];

endmodule

// File: rtl/msix_vec_store.sv
module msix_vec_store
  import msix_resp_pkg::*;
#(
  parameter int unsigned NUM_VEC = 8,
  parameter int unsigned IDX_W   = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_pair_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [1:0]       wr_dw_i,
  input  logic [63:0]      wr_data_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output vec_entry_t       rd_entry_o,
  input  logic [IDX_W-1:0] msg_idx_i,
  output logic [7:0]       msg_dest_o,
  output logic [7:0]       msg_vec_o,
  output logic             msg_masked_o
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  vec_entry_t mem [DEPTH];
  logic [1:0] hi_dw;

  assign hi_dw = wr_dw_i | 2'b01;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    if (g < NUM_VEC) begin : g_live
      vec_entry_t ent_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          ent_q <= '0;
          ent_q[DW_VCTRL] <= 32'h1;
        end else if (wr_en_i && wr_idx_i == IDX_W'(g)) begin
          for (int w = 0; w < 4; w++) begin
            if (wr_pair_i && hi_dw == 2'(w)) ent_q[w] <= wr_data_i[63:32];
            else if (wr_dw_i == 2'(w))       ent_q[w] <= wr_data_i[31:0];
          end
        end
      end
      assign mem[g] = ent_q;
    end else begin : g_pad
      assign mem[g] = '0;
    end
  end

  assign rd_entry_o   = mem[rd_idx_i];
  assign msg_dest_o   = mem[msg_idx_i][DW_ADDR_LO][19:12];
  assign msg_vec_o    = mem[msg_idx_i][DW_DATA][7:0];
  assign msg_masked_o = mem[msg_idx_i][DW_VCTRL][0];

endmodule

// File: rtl/msix_msg_gate.sv
module msix_msg_gate (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       trig_valid_i,
  input  logic       trig_in_range_i,
  input  logic       msix_en_i,
  input  logic       msix_fmask_i,
  input  logic       msi_en_i,
  input  logic       vec_masked_i,
  input  logic [7:0] dest_i,
  input  logic [7:0] vec_i,
  output logic       msg_valid_o,
  output logic [7:0] msg_dest_o,
  output logic [7:0] msg_vec_o
);
  logic fire;

  // plain MSI wins over vector messaging
  assign fire = trig_valid_i & trig_in_range_i & msix_en_i & ~msi_en_i
              & ~msix_fmask_i & ~vec_masked_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msg_valid_o <= 1'b0;
      msg_dest_o  <= '0;
      msg_vec_o   <= '0;
    end else begin
      msg_valid_o <= fire;
      if (fire) begin
        msg_dest_o <= dest_i;
        msg_vec_o  <= vec_i;
      end
    end
  end

  a_r8_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |-> $past(msix_en_i && !msix_fmask_i && trig_valid_i));
  a_r8_needs_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |-> $past(trig_in_range_i));
  a_r10_msi_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msi_en_i |=> !msg_valid_o);

endmodule

// File: rtl/msix_bar_resp.sv
module msix_bar_resp
  import msix_resp_pkg::*;
#(
  parameter int unsigned NUM_VEC = 8,
  parameter int unsigned BAR_AW  = 13,
  parameter int unsigned TRIG_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [BAR_AW-1:0] req_addr_i,
  input  logic [3:0]        req_size_i,
  input  logic [63:0]       req_wdata_i,
  output logic              rsp_valid_o,
  output logic [63:0]       rsp_rdata_o,
  input  logic              msix_en_i,
  input  logic              msix_fmask_i,
  input  logic              msi_en_i,
  input  logic              trig_valid_i,
  input  logic [TRIG_W-1:0] trig_index_i,
  output logic              msg_valid_o,
  output logic [7:0]        msg_dest_o,
  output logic [7:0]        msg_vec_o
);
  localparam int unsigned IDX_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;

  logic             size_ok, size8, aligned, in_table, in_pba;
  logic [IDX_W-1:0] idx;
  logic [1:0]       dw;
  vec_entry_t       rd_entry;
  logic             wr_en, rd_req, acc_ok;
  logic [63:0]      rd_data;
  logic             trig_in_range;
  logic [7:0]       ent_dest, ent_vec;
  logic             ent_masked;

  msix_acc_decode #(.NUM_VEC(NUM_VEC), .ADDR_W(BAR_AW), .IDX_W(IDX_W)) u_dec (
    .addr_i(req_addr_i), .size_i(req_size_i),
    .size_ok_o(size_ok), .size8_o(size8), .aligned_o(aligned),
    .in_table_o(in_table), .in_pba_o(in_pba), .idx_o(idx), .dw_o(dw)
  );

  assign acc_ok = size_ok & aligned;
  assign wr_en  = req_valid_i & req_write_i & acc_ok & in_table;
  assign rd_req = req_valid_i & ~req_write_i;

  assign trig_in_range = (trig_index_i < TRIG_W'(NUM_VEC));

  msix_vec_store #(.NUM_VEC(NUM_VEC), .IDX_W(IDX_W)) u_store (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_pair_i(size8), .wr_idx_i(idx), .wr_dw_i(dw),
    .wr_data_i(req_wdata_i),
    .rd_idx_i(idx), .rd_entry_o(rd_entry),
    .msg_idx_i(trig_index_i[IDX_W-1:0]),
    .msg_dest_o(ent_dest), .msg_vec_o(ent_vec), .msg_masked_o(ent_masked)
  );

  always_comb begin
    if (!acc_ok)       rd_data = '1;
    else if (in_table) rd_data = size8 ? {rd_entry[dw | 2'b01], rd_entry[dw]}
                                       : {32'h0, rd_entry[dw]};
    else if (in_pba)   rd_data = '0;
    else               rd_data = '1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= rd_req;
      if (rd_req) rsp_rdata_o <= rd_data;
    end
  end

  msix_msg_gate u_gate (
    .clk_i, .rst_ni,
    .trig_valid_i, .trig_in_range_i(trig_in_range),
    .msix_en_i, .msix_fmask_i, .msi_en_i,
    .vec_masked_i(ent_masked), .dest_i(ent_dest), .vec_i(ent_vec),
    .msg_valid_o, .msg_dest_o, .msg_vec_o
  );

  a_r7_rsp_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i) |=> rsp_valid_o);
  a_r7_no_rsp_else: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && !req_write_i) |=> !rsp_valid_o);
  a_r1_bad_size_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i && req_size_i != 4'd4 && req_size_i != 4'd8)
    |=> (rsp_rdata_o == '1));
  a_r5_pba_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i && size_ok && aligned && in_pba && !in_table)
    |=> (rsp_rdata_o == '0));

endmodule

// File: tb/msix_bar_resp_tb_top.sv
`timescale 1ns/1ps
module msix_bar_resp_tb_top;
  localparam int unsigned AW = 13;
  localparam int unsigned TW = 6;
  localparam logic [63:0] ONES = '1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [3:0]    req_size = '0;
  logic [63:0]   req_wdata = '0;
  logic          rsp_valid;
  logic [63:0]   rsp_rdata;
  logic          msix_en = 1'b0, fmask = 1'b0, msi_en = 1'b0;
  logic          trig_valid = 1'b0;
  logic [TW-1:0] trig_index = '0;
  logic          msg_valid;
  logic [7:0]    msg_dest, msg_vec;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [63:0] rd_exp_q[$];
  string       rd_tag_q[$];
  logic        msg_fire_q[$];
  logic [15:0] msg_exp_q[$];
  string       msg_tag_q[$];

  always #2.5 clk = ~clk;

  msix_bar_resp #(.NUM_VEC(8), .BAR_AW(AW), .TRIG_W(TW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
    .req_size_i(req_size), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .msix_en_i(msix_en), .msix_fmask_i(fmask), .msi_en_i(msi_en),
    .trig_valid_i(trig_valid), .trig_index_i(trig_index),
    .msg_valid_o(msg_valid), .msg_dest_o(msg_dest), .msg_vec_o(msg_vec)
  );

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(logic [AW-1:0] a, logic [3:0] sz, logic [63:0] d, string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_size = sz; req_wdata = d;
    @(posedge clk); #1;
    check(rsp_valid == 1'b0, {tag, " R7 no response to write"}, 64'(rsp_valid), 64'h0);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_rd(logic [AW-1:0] a, logic [3:0] sz, logic [63:0] e, string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = sz;
    rd_exp_q.push_back(e); rd_tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic trig(logic [TW-1:0] i, logic fire, logic [7:0] d, logic [7:0] v, string tag);
    @(negedge clk);
    trig_valid = 1'b1; trig_index = i;
    msg_fire_q.push_back(fire); msg_exp_q.push_back({d, v}); msg_tag_q.push_back(tag);
    @(negedge clk);
    trig_valid = 1'b0;
  endtask

  // scoreboard monitor: results land on the edge after the request
  always begin
    @(posedge clk); #1;
    if (rst_n && !done) begin
      if (rd_exp_q.size() > 0) begin
        automatic logic [63:0] e = rd_exp_q.pop_front();
        automatic string t = rd_tag_q.pop_front();
        check(rsp_valid == 1'b1, {t, " R7 response valid"}, 64'(rsp_valid), 64'h1);
        check(rsp_rdata == e, t, rsp_rdata, e);
      end else if (rsp_valid) begin
        check(1'b0, "R7 unexpected response", 64'h1, 64'h0);
      end
      if (msg_fire_q.size() > 0) begin
        automatic logic f = msg_fire_q.pop_front();
        automatic logic [15:0] e = msg_exp_q.pop_front();
        automatic string t = msg_tag_q.pop_front();
        check(msg_valid == f, {t, " message strobe"}, 64'(msg_valid), 64'(f));
        if (f) check({msg_dest, msg_vec} == e, {t, " R9 dest/vector"},
                     64'({msg_dest, msg_vec}), 64'(e));
      end else if (msg_valid) begin
        check(1'b0, "R8 unexpected message", 64'h1, 64'h0);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(rsp_valid == 1'b0 && msg_valid == 1'b0, "R6 outputs idle in reset",
          64'({rsp_valid, msg_valid}), 64'h0);
    @(negedge clk); rst_n = 1'b1;

    // R6 reset contents
    bus_rd(13'h00C, 4'd4, 64'h1, "R6 entry0 vctrl");
    bus_rd(13'h07C, 4'd4, 64'h1, "R6 entry7 vctrl");
    bus_rd(13'h000, 4'd8, 64'h0, "R6 entry0 address");

    // R2 dword writes and zero-extended reads
    bus_wr(13'h020, 4'd4, 64'hDEAD_0000_000A_B000, "R2");
    bus_wr(13'h028, 4'd4, 64'h0000_0000_0000_0031, "R2");
    bus_rd(13'h020, 4'd4, 64'h0000_0000_000A_B000, "R2 addr lo");
    bus_rd(13'h028, 4'd4, 64'h31, "R2 data");
    bus_rd(13'h024, 4'd4, 64'h0, "R2 addr hi untouched");

    // R3 paired writes and alignment
    bus_wr(13'h030, 4'd8, 64'h0000_0001_000C_D000, "R3");
    bus_rd(13'h030, 4'd8, 64'h0000_0001_000C_D000, "R3 8-byte read");
    bus_rd(13'h034, 4'd4, 64'h1, "R3 high dword");
    bus_wr(13'h034, 4'd8, 64'h5555_5555_6666_6666, "R3");
    bus_rd(13'h034, 4'd4, 64'h1, "R3 misaligned write dropped");
    bus_rd(13'h038, 4'd4, 64'h0, "R3 misaligned write no spill");
    bus_rd(13'h034, 4'd8, ONES, "R3 misaligned 8-byte read");
    bus_rd(13'h022, 4'd4, ONES, "R3 misaligned 4-byte read");

    // R1 illegal sizes
    bus_wr(13'h028, 4'd2, 64'hFFFF, "R1");
    bus_rd(13'h028, 4'd4, 64'h31, "R1 2-byte write ignored");
    bus_rd(13'h028, 4'd2, ONES, "R1 2-byte read");
    bus_rd(13'h020, 4'd1, ONES, "R1 1-byte read");

    // R4 out-of-range index
    bus_wr(13'h080, 4'd4, 64'h5, "R4");
    bus_rd(13'h000, 4'd4, 64'h0, "R4 no alias into entry0");
    bus_rd(13'h080, 4'd4, ONES, "R4 read beyond table");

    // R5 pending array
    bus_rd(13'h1000, 4'd8, 64'h0, "R5 pending word");
    bus_rd(13'h1004, 4'd4, 64'h0, "R5 pending upper dword");
    bus_rd(13'h1008, 4'd4, ONES, "R5 past pending array");
    bus_rd(13'h0FF0, 4'd4, ONES, "R5 gap below pending array");

    // R8/R9/R10 message gating
    @(negedge clk); msix_en = 1'b1;
    trig(6'd2, 1'b0, 8'h0, 8'h0, "R8 entry masked");
    bus_wr(13'h02C, 4'd4, 64'h0, "R8 unmask entry2");
    trig(6'd2, 1'b1, 8'hAB, 8'h31, "R9 entry2 message");
    @(negedge clk); fmask = 1'b1;
    trig(6'd2, 1'b0, 8'h0, 8'h0, "R8 function mask");
    @(negedge clk); fmask = 1'b0; msi_en = 1'b1;
    trig(6'd2, 1'b0, 8'h0, 8'h0, "R10 MSI overrides");
    @(negedge clk); msi_en = 1'b0; msix_en = 1'b0;
    trig(6'd2, 1'b0, 8'h0, 8'h0, "R8 disabled");
    @(negedge clk); msix_en = 1'b1;
    trig(6'd9, 1'b0, 8'h0, 8'h0, "R8 index out of range");
    bus_wr(13'h038, 4'd8, 64'h0000_0000_0000_01FF, "R3 data+vctrl pair");
    trig(6'd3, 1'b1, 8'hCD, 8'hFF, "R9 entry3 message");
    bus_rd(13'h03C, 4'd4, 64'h0, "R3 vctrl from pair write");

    repeat (4) @(negedge clk);
    check(rd_exp_q.size() == 0 && msg_fire_q.size() == 0, "R7 scoreboard drained",
          64'(rd_exp_q.size() + msg_fire_q.size()), 64'h0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule